// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Interrupts

This block holds the data path between a register interface and a serial engine. It has two byte queues. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. Each queue can be switched on and off. Each reports its fill level on a 7-bit field, so a full 64-entry queue reads as 64. Each also reports full and empty. Error pulses are raised when a queue is pushed while full or popped while empty.

A ten-bit interrupt status register gathers these conditions:
- a transmit almost-empty condition and a receive almost-full condition, each compared against a trigger level,
- the four overrun and underrun errors,
- a trailing-data event, raised when a small receive residue sits untouched for a programmable number of cycles,
- an external transfer event.

Status bits are sticky and are cleared by writing ones. A single interrupt line is the OR of the status bits masked by a per-bit enable vector. Software reads the packed status word and the interrupt status. It takes the interrupt line to a handler.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset with both queues disabled, `fifo_status` reads 32'h0100_0100, `int_status` reads zero, `irq` is low and `host_rx_data` is zero.
- R2: Each queue returns bytes in push order, up to DEPTH (64) entries. `fifo_status` packs these fields (all other bits are zero):

  | Bits | Field |
  |------|-------|
  | 6:0 | TX level |
  | 7 | TX full |
  | 8 | TX empty |
  | 22:16 | RX level |
  | 23 | RX full |
  | 24 | RX empty |

  The read data of each queue is its oldest entry, visible in the same cycle as the pop.
- R3: A push into a full queue drops the byte, leaves the level unchanged and sets overrun: `int_status` bit 3 for TX, bit 5 for RX.
- R4: A pop from an empty queue returns 8'h00 and sets underrun: `int_status` bit 2 for TX, bit 4 for RX.
- R5: While a queue is disabled it reads empty with level 0, its contents are discarded, its read data is zero, and pushes and pops are ignored without setting error bits.
- R6: `int_status` bit 0 is set on every cycle in which TX is enabled and the TX level is at or below `tx_trig`.
- R7: `int_status` bit 1 is set on every cycle in which RX is enabled and the RX level is at or above `rx_trig`.
- R8: `int_status` bit 6 is set once, when RX has held a level between 1 and `rx_trig`-1 with no RX push and no RX pop for `trail_limit` consecutive cycles (15 in normal use). Any RX push or pop restarts the count.
- R9: A high `xfer_evt` sets `int_status` bit 9.
- R10: On a write with `int_clr_wr`, each set bit of `int_clr_mask` clears the matching status bit. Zero bits leave their status bit alone. A set condition in the same cycle wins over the clear. Bits 7 and 8 always read zero.
- R11: `irq` is high exactly when some bit of `int_status` and the same bit of `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit queue enable |
| rx_en | input | 1 | Receive queue enable |
| tx_trig | input | LVL_W (7) | Transmit almost-empty trigger level |
| rx_trig | input | LVL_W (7) | Receive almost-full trigger level |
| trail_limit | input | TRAIL_W (8) | Idle cycles before the trailing event |
| host_tx_wr | input | 1 | Host pushes a transmit byte |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_rd | input | 1 | Host pops a receive byte |
| host_rx_data | output | 8 | Oldest receive byte, or zero |
| eng_tx_rd | input | 1 | Engine pops a transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte, or zero |
| eng_rx_wr | input | 1 | Engine pushes a receive byte |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| xfer_evt | input | 1 | Transfer event from the engine |
| irq_en | input | 10 | Per-bit interrupt enables |
| int_clr_wr | input | 1 | Write strobe for the clear mask |
| int_clr_mask | input | 10 | Write-one-to-clear mask |
| int_status | output | 10 | Sticky interrupt status |
| fifo_status | output | 32 | Packed level, full and empty fields |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach from the ports is the trailing event. It needs a receive residue below the trigger level and an exact run of untouched cycles, and it must fire once rather than on every later idle cycle. The stimulus works in three steps:
1. It pushes three bytes, holds every receive strobe low and samples bit 6 after each edge, so the single firing cycle is pinned down.
2. It clears the bit, idles further and pops one byte to restart the count, so a second firing is checked.
3. It fills the queue to the trigger level, where no firing may occur.

The trigger comparisons are swept level by level from 0 to 64, clearing the bit before each sample so that a stale sticky value cannot hide a wrong comparison.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

   // Interrupt status bit positions (decoded by software, so fixed)
   localparam int INT_W      = 10;
   localparam int ST_TX_AE   = 0;
   localparam int ST_RX_AF   = 1;
   localparam int ST_TX_UNF  = 2;
   localparam int ST_TX_OVF  = 3;
   localparam int ST_RX_UNF  = 4;
   localparam int ST_RX_OVF  = 5;
   localparam int ST_TRAIL   = 6;
   localparam int ST_XFER    = 9;

   // Implemented status bits; the rest are tied to zero
   localparam logic [INT_W-1:0] IMPL_MASK = 10'b10_0111_1111;

   // Width of each level field in the packed status word
   localparam int STAT_LVL_W = 7;

   typedef struct packed {
      logic                  empty;
      logic                  full;
      logic [STAT_LVL_W-1:0] level;
   } q_view_t;

   function automatic logic [31:0] pack_status(input q_view_t txv, input q_view_t rxv);
      logic [31:0] w;
      w        = '0;
      w[8:0]   = txv;
      w[24:16] = rxv;
      return w;
   endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
   parameter  int DEPTH = 64,
   parameter  int DW    = 8,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wr,
   input  logic [DW-1:0]    wdata,
   input  logic             rd,
   output logic [DW-1:0]    rdata,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             ovf,
   output logic             unf
);

   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   initial begin : p_elab_chk
      assert (DEPTH >= 2) else $error("byte_fifo: DEPTH must be at least 2");
      assert (DW >= 1)    else $error("byte_fifo: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = en & wr & ~full;
   assign pop_ok  = en & rd & ~empty;
   assign ovf     = en & wr & full;
   assign unf     = en & rd & empty;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (!en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   assign rdata = (en && !empty) ? mem[rd_ptr] : '0;

   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   a_r3_overrun_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr && full && !rd) |=> $stable(level));

   a_r4_underrun_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rd && empty && !wr) |=> empty);

   a_r5_off_reads_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (level == '0));

endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
   parameter int LVL_W = 7,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] trig,
   input  logic             activity,
   input  logic [CNT_W-1:0] limit,
   output logic             fire
);

   initial begin : p_elab_chk
      assert (CNT_W >= 1) else $error("trail_timer: CNT_W must be positive");
   end

   logic [CNT_W-1:0] cnt;
   logic             residue;
   logic             at_limit;

   assign residue  = en && (level != '0) && (level < trig);
   assign at_limit = (cnt == limit);
   assign fire     = residue && !activity &&
                     (({1'b0, cnt} + 1'b1) == {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!residue || activity) cnt <= '0;
      else if (!at_limit)           cnt <= cnt + 1'b1;
   end

   a_r8_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/int_status_reg.sv
module int_status_reg
   import fifo_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INT_W-1:0] set,
   input  logic             clr_wr,
   input  logic [INT_W-1:0] clr_mask,
   input  logic [INT_W-1:0] irq_en,
   output logic [INT_W-1:0] stat,
   output logic             irq
);

   generate
      for (genvar b = 0; b < INT_W; b++) begin : g_bit
         if (IMPL_MASK[b]) begin : g_flop
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q <= 1'b0;
               else        q <= (q & ~(clr_wr & clr_mask[b])) | set[b];
            end
            assign stat[b] = q;

            a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_wr && clr_mask[b] && !set[b]) |=> !q);

            a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
               set[b] |=> q);
         end else begin : g_tie
            logic unused_bit;
            assign unused_bit = set[b] ^ clr_mask[b];
            assign stat[b]    = 1'b0;
         end
      end
   endgenerate

   assign irq = |(stat & irq_en);

   a_r9_xfer_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set[ST_XFER] |=> stat[ST_XFER]);

endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
   import fifo_irq_pkg::*;
#(
   parameter  int DEPTH   = 64,
   parameter  int TRAIL_W = 8,
   localparam int LVL_W   = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_en,
   input  logic               rx_en,
   input  logic [LVL_W-1:0]   tx_trig,
   input  logic [LVL_W-1:0]   rx_trig,
   input  logic [TRAIL_W-1:0] trail_limit,
   input  logic               host_tx_wr,
   input  logic [7:0]         host_tx_data,
   input  logic               host_rx_rd,
   output logic [7:0]         host_rx_data,
   input  logic               eng_tx_rd,
   output logic [7:0]         eng_tx_data,
   input  logic               eng_rx_wr,
   input  logic [7:0]         eng_rx_data,
   input  logic               xfer_evt,
   input  logic [INT_W-1:0]   irq_en,
   input  logic               int_clr_wr,
   input  logic [INT_W-1:0]   int_clr_mask,
   output logic [INT_W-1:0]   int_status,
   output logic [31:0]        fifo_status,
   output logic               irq
);

   initial begin : p_elab_chk
      assert (LVL_W <= STAT_LVL_W) else $error("dual_fifo_irq: DEPTH too large for status field");
   end

   logic [LVL_W-1:0] tx_lvl, rx_lvl;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic             tx_ovf, tx_unf, rx_ovf, rx_unf;
   logic             trail_fire;
   logic [INT_W-1:0] set_vec;
   q_view_t          tx_view, rx_view;

   byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
      .clk(clk), .rst_n(rst_n), .en(tx_en),
      .wr(host_tx_wr), .wdata(host_tx_data),
      .rd(eng_tx_rd), .rdata(eng_tx_data),
      .level(tx_lvl), .full(tx_full), .empty(tx_empty),
      .ovf(tx_ovf), .unf(tx_unf)
   );

   byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
      .clk(clk), .rst_n(rst_n), .en(rx_en),
      .wr(eng_rx_wr), .wdata(eng_rx_data),
      .rd(host_rx_rd), .rdata(host_rx_data),
      .level(rx_lvl), .full(rx_full), .empty(rx_empty),
      .ovf(rx_ovf), .unf(rx_unf)
   );

   trail_timer #(.LVL_W(LVL_W), .CNT_W(TRAIL_W)) u_trail (
      .clk(clk), .rst_n(rst_n), .en(rx_en),
      .level(rx_lvl), .trig(rx_trig),
      .activity(host_rx_rd | eng_rx_wr),
      .limit(trail_limit), .fire(trail_fire)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[ST_TX_AE]  = tx_en && (tx_lvl <= tx_trig);
      set_vec[ST_RX_AF]  = rx_en && (rx_lvl >= rx_trig);
      set_vec[ST_TX_UNF] = tx_unf;
      set_vec[ST_TX_OVF] = tx_ovf;
      set_vec[ST_RX_UNF] = rx_unf;
      set_vec[ST_RX_OVF] = rx_ovf;
      set_vec[ST_TRAIL]  = trail_fire;
      set_vec[ST_XFER]   = xfer_evt;
   end

   int_status_reg u_ists (
      .clk(clk), .rst_n(rst_n), .set(set_vec),
      .clr_wr(int_clr_wr), .clr_mask(int_clr_mask),
      .irq_en(irq_en), .stat(int_status), .irq(irq)
   );

   assign tx_view     = '{empty: tx_empty, full: tx_full, level: STAT_LVL_W'(tx_lvl)};
   assign rx_view     = '{empty: rx_empty, full: rx_full, level: STAT_LVL_W'(rx_lvl)};
   assign fifo_status = pack_status(tx_view, rx_view);

   a_r3_tx_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && host_tx_wr && tx_full) |=> int_status[ST_TX_OVF]);

   a_r4_rx_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && host_rx_rd && rx_empty) |=> int_status[ST_RX_UNF]);

endmodule

// File: tb/dual_fifo_irq_bench.sv
module dual_fifo_irq_bench;

   localparam int DEPTH = 64;
   localparam int LW    = 7;
   localparam int TW    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tx_en, rx_en;
   logic [LW-1:0] tx_trig, rx_trig;
   logic [TW-1:0] trail_limit;
   logic          host_tx_wr, host_rx_rd, eng_tx_rd, eng_rx_wr, xfer_evt;
   logic [7:0]    host_tx_data, host_rx_data, eng_tx_data, eng_rx_data;
   logic [9:0]    irq_en, int_clr_mask, int_status;
   logic          int_clr_wr, irq;
   logic [31:0]   fifo_status;

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   dual_fifo_irq u_dual_fifo_irq (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
      .tx_trig(tx_trig), .rx_trig(rx_trig), .trail_limit(trail_limit),
      .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
      .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
      .eng_tx_rd(eng_tx_rd), .eng_tx_data(eng_tx_data),
      .eng_rx_wr(eng_rx_wr), .eng_rx_data(eng_rx_data),
      .xfer_evt(xfer_evt), .irq_en(irq_en),
      .int_clr_wr(int_clr_wr), .int_clr_mask(int_clr_mask),
      .int_status(int_status), .fifo_status(fifo_status), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc;
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [7:0] pat(input int i, input int s);
      return 8'(i * 37 + s * 11 + 5);
   endfunction

   task automatic clr_bits(input logic [9:0] m);
      int_clr_wr   = 1'b1;
      int_clr_mask = m;
      cyc();
      int_clr_wr   = 1'b0;
      int_clr_mask = '0;
   endtask

   initial begin : p_watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin : p_main
      rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
      tx_trig = 7'd16; rx_trig = 7'd48; trail_limit = 8'd15;
      host_tx_wr = 0; host_rx_rd = 0; eng_tx_rd = 0; eng_rx_wr = 0; xfer_evt = 0;
      host_tx_data = 0; eng_rx_data = 0; irq_en = '0; int_clr_wr = 0; int_clr_mask = 0;
      repeat (3) cyc();

      // R1 reset state
      check("R1 status word", fifo_status, 32'h0100_0100);
      check("R1 int_status", {22'd0, int_status}, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 rx data", {24'd0, host_rx_data}, 32'd0);
      rst_n = 1'b1;
      cyc();
      check("R1 disabled no status", {22'd0, int_status}, 32'd0);
      tx_en = 1'b1; rx_en = 1'b1;
      cyc();

      // R2 TX fill sweep
      for (int i = 0; i < DEPTH; i++) begin
         host_tx_wr = 1'b1; host_tx_data = pat(i, 0);
         cyc();
         check("R2 tx fill", {23'd0, fifo_status[8:0]}, {23'd0, 1'b0, (i == DEPTH - 1), 7'(i + 1)});
      end
      host_tx_wr = 1'b0;
      clr_bits('1);

      // R3 TX overrun
      host_tx_wr = 1'b1; host_tx_data = 8'hEE;
      cyc();
      host_tx_wr = 1'b0;
      check("R3 tx overrun bit3", {31'd0, int_status[3]}, 32'd1);
      check("R3 tx level held", {25'd0, fifo_status[6:0]}, 32'd64);

      // R2 TX drain order
      for (int i = 0; i < DEPTH; i++) begin
         eng_tx_rd = 1'b1;
         #1;
         check("R2 tx order", {24'd0, eng_tx_data}, {24'd0, pat(i, 0)});
         cyc();
         check("R2 tx level", {25'd0, fifo_status[6:0]}, 32'(DEPTH - 1 - i));
      end

      // R4 TX underrun
      #1;
      check("R4 tx empty data zero", {24'd0, eng_tx_data}, 32'd0);
      cyc();
      eng_tx_rd = 1'b0;
      check("R4 tx underrun bit2", {31'd0, int_status[2]}, 32'd1);
      check("R2 tx empty flag", {31'd0, fifo_status[8]}, 32'd1);

      // R6 almost-empty sweep over all levels
      for (int l = 0; l <= DEPTH; l++) begin
         if (l > 0) begin
            host_tx_wr = 1'b1; host_tx_data = pat(l, 2);
            cyc();
            host_tx_wr = 1'b0;
         end
         clr_bits(10'h001);
         check("R6 almost-empty", {31'd0, int_status[0]}, {31'd0, (l <= 16)});
      end
      eng_tx_rd = 1'b1;
      repeat (DEPTH) cyc();
      eng_tx_rd = 1'b0;

      // R7 almost-full sweep over all levels
      for (int l = 0; l <= DEPTH; l++) begin
         if (l > 0) begin
            eng_rx_wr = 1'b1; eng_rx_data = pat(l - 1, 1);
            cyc();
            eng_rx_wr = 1'b0;
         end
         clr_bits(10'h002);
         check("R7 almost-full", {31'd0, int_status[1]}, {31'd0, (l >= 48)});
      end
      check("R2 rx full flags", {23'd0, fifo_status[24:16]}, {23'd0, 2'b01, 7'd64});

      // R3 RX overrun
      clr_bits(10'h020);
      eng_rx_wr = 1'b1; eng_rx_data = 8'hC3;
      cyc();
      eng_rx_wr = 1'b0;
      check("R3 rx overrun bit5", {31'd0, int_status[5]}, 32'd1);
      check("R3 rx level held", {25'd0, fifo_status[22:16]}, 32'd64);

      // R2 RX drain order
      for (int i = 0; i < DEPTH; i++) begin
         host_rx_rd = 1'b1;
         #1;
         check("R2 rx order", {24'd0, host_rx_data}, {24'd0, pat(i, 1)});
         cyc();
      end

      // R4 RX underrun
      #1;
      check("R4 rx empty data zero", {24'd0, host_rx_data}, 32'd0);
      cyc();
      host_rx_rd = 1'b0;
      check("R4 rx underrun bit4", {31'd0, int_status[4]}, 32'd1);

      // R8 trailing event timing
      clr_bits('1);
      for (int j = 0; j < 3; j++) begin
         eng_rx_wr = 1'b1; eng_rx_data = pat(j, 3);
         cyc();
      end
      eng_rx_wr = 1'b0;
      for (int k = 1; k <= 15; k++) begin
         cyc();
         check("R8 trailing first", {31'd0, int_status[6]}, {31'd0, (k == 15)});
      end
      clr_bits(10'h040);
      check("R8 trailing cleared", {31'd0, int_status[6]}, 32'd0);
      repeat (20) cyc();
      check("R8 trailing fires once", {31'd0, int_status[6]}, 32'd0);
      host_rx_rd = 1'b1;
      cyc();
      host_rx_rd = 1'b0;
      for (int k = 1; k <= 15; k++) begin
         cyc();
         check("R8 trailing after pop", {31'd0, int_status[6]}, {31'd0, (k == 15)});
      end
      clr_bits(10'h040);
      for (int j = 0; j < 46; j++) begin
         eng_rx_wr = 1'b1; eng_rx_data = pat(j, 4);
         cyc();
      end
      eng_rx_wr = 1'b0;
      repeat (30) cyc();
      check("R8 no trailing at trigger", {31'd0, int_status[6]}, 32'd0);
      host_rx_rd = 1'b1;
      repeat (48) cyc();
      host_rx_rd = 1'b0;

      // R9 / R10 transfer event and clear rules
      clr_bits('1);
      xfer_evt = 1'b1;
      cyc();
      xfer_evt = 1'b0;
      check("R9 xfer bit9", {31'd0, int_status[9]}, 32'd1);
      clr_bits(10'h000);
      check("R10 zero mask keeps", {31'd0, int_status[9]}, 32'd1);
      xfer_evt = 1'b1;
      clr_bits(10'h200);
      xfer_evt = 1'b0;
      check("R10 set wins", {31'd0, int_status[9]}, 32'd1);
      check("R10 full word", {22'd0, int_status}, 32'h201);

      // R11 interrupt masking sweep
      for (int b = 0; b < 10; b++) begin
         irq_en = 10'(1 << b);
         #1;
         check("R11 irq one-hot", {31'd0, irq}, {31'd0, (b == 0 || b == 9)});
      end
      irq_en = 10'h1FE & ~10'h200;
      #1;
      check("R11 irq masked", {31'd0, irq}, 32'd0);
      irq_en = '0;
      clr_bits(10'h200);
      check("R10 bit9 cleared", {31'd0, int_status[9]}, 32'd0);

      // R5 disable behaviour
      for (int j = 0; j < 5; j++) begin
         eng_rx_wr = 1'b1; eng_rx_data = pat(j, 5);
         cyc();
      end
      eng_rx_wr = 1'b0;
      clr_bits('1);
      rx_en = 1'b0;
      cyc();
      check("R5 rx flushed", {23'd0, fifo_status[24:16]}, 32'h100);
      eng_rx_wr = 1'b1; eng_rx_data = 8'h77; host_rx_rd = 1'b1;
      #1;
      check("R5 rx data zero", {24'd0, host_rx_data}, 32'd0);
      cyc();
      eng_rx_wr = 1'b0; host_rx_rd = 1'b0;
      check("R5 rx ignored", {23'd0, fifo_status[24:16]}, 32'h100);
      check("R5 no rx errors", {30'd0, int_status[5:4]}, 32'd0);
      rx_en = 1'b1;
      eng_rx_wr = 1'b1; eng_rx_data = 8'h5A;
      cyc();
      eng_rx_wr = 1'b0;
      check("R5 rx restart level", {25'd0, fifo_status[22:16]}, 32'd1);
      check("R5 rx no stale data", {24'd0, host_rx_data}, 32'h5A);
      tx_en = 1'b0;
      eng_tx_rd = 1'b1;
      clr_bits(10'h005);
      eng_tx_rd = 1'b0;
      check("R5 tx no underrun off", {31'd0, int_status[2]}, 32'd0);
      check("R6 gated when off", {31'd0, int_status[0]}, 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule